// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a synchronous burst memory front end. An access opens when one of two address strobes is low at a clock edge: the processor-side strobe or the controller-side strobe. The external address is then loaded into a register. While the burst continues, an active-low advance input steps a two-bit beat counter. The counter changes only the two least significant address bits. The bits above them keep the value loaded at the start.

An order input is sampled at load and held for the whole burst. Low selects wrap-around linear stepping. High selects interleaved stepping, in which the start bits are XORed with the beat count.

Before an access opens, the sequencer qualifies the three chip enables. Enable 1 masks the processor strobe. Enables 2 and 3 count only at a strobe edge. The block also reports whether the current cycle is a read or a write. A processor-strobe start is always a read. A write can follow only on a later cycle, at the same or a stepped address. The downstream memory block receives the full address, a valid flag and the cycle type. All three are registered and change at the rising clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: With order_i low at load, the two low address bits equal (start bits + beat count) mod 4.
- R2: With order_i high at load, the two low address bits equal start bits XOR beat count. The order chosen at load holds for the rest of the burst.
- R3: The address bits above the low two keep their loaded value for the whole burst. After the fourth beat the count wraps to zero and the sequence repeats in the same order.
- R4: When adv_ni is high and no strobe starts an access, addr_o and valid_o keep their values (suspend).
- R5: An access started by ads_cpu_ni is always a read: cyc_wr_o is 0 (0 = read, 1 = write), whatever wr_ni is.
- R6: In a continuing or suspended cycle of a valid burst, cyc_wr_o equals the inverse of wr_ni, so a write can follow a processor-started read.
- R7: While ce1_ni is high, ads_cpu_ni low has no effect. Address, valid and burst position are unchanged.
- R8: A strobe edge with ce1_ni high, ce2_i low or ce3_ni high deselects: valid_o becomes 0 and the address does not step or load.
- R9: ce2_i and ce3_ni are ignored on cycles where no strobe starts an access; the burst keeps stepping.
- R10: If both strobes are low and ce1_ni is low, the processor strobe wins and the cycle starts as a read.
- R11: During reset and after it, addr_o is 0, valid_o is 0 and cyc_wr_o is 0 until an access starts.
- R12: An access started by ads_ctl_ni alone takes its type from wr_ni at that edge: low gives a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External start address |
| ads_cpu_ni | input | 1 | Processor-side address strobe, active low |
| ads_ctl_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Chip enable 1, active low, masks processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| wr_ni | input | 1 | Write request, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | AW | Current full address |
| valid_o | output | 1 | Address belongs to a selected access |
| cyc_wr_o | output | 1 | Cycle type: 0 read, 1 write |

## Verification
The embedded properties check on every clock the relations that hold for any input pattern:
- suspend holds the address;
- the upper bits stay frozen during a burst;
- a processor start is a read;
- a failed enable qualification deselects;
- the processor strobe wins over the controller strobe;
- the beat counter steps by one.

The actual linear and interleaved sequences from each start value, the wrap after the fourth beat, masking by enable 1, and a write after a processor-started read are value-specific. Only the bench's directed vectors with precomputed addresses show them.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {CYC_RD = 1'b0, CYC_WR = 1'b1} cyc_kind_e;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} burst_ord_e;

  typedef struct packed {
    logic start;  // some strobe opens an access
    logic proc;   // the processor strobe is the one that opens it
    logic sel;    // chip enables qualify the access
  } strobe_dec_t;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import burst_seq_pkg::*;
(
  input  logic        ads_cpu_ni,
  input  logic        ads_ctl_ni,
  input  logic        ce1_ni,
  input  logic        ce2_i,
  input  logic        ce3_ni,
  output strobe_dec_t dec_o
);
  logic proc_hit;

  // enable 1 gates the processor strobe; the processor strobe wins when both are low
  assign proc_hit    = ~ads_cpu_ni & ~ce1_ni;
  assign dec_o.proc  = proc_hit;
  assign dec_o.start = proc_hit | ~ads_ctl_ni;
  assign dec_o.sel   = ~ce1_ni & ce2_i & ~ce3_ni;
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  // R1
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i) |=> cnt_q == $past(cnt_q) + CW'(1));

  // R3
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/beat_order.sv
module beat_order
  import burst_seq_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] cnt_i,
  input  burst_ord_e    ord_i,
  output logic [CW-1:0] beat_o
);
  logic [CW-1:0] lin_beat;
  logic [CW-1:0] xor_beat;

  assign lin_beat = start_i + cnt_i;
  assign xor_beat = start_i ^ cnt_i;

  always_comb begin
    unique case (ord_i)
      ORD_XOR: beat_o = xor_beat;
      default: beat_o = lin_beat;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ads_cpu_ni,
  input  logic          ads_ctl_ni,
  input  logic          adv_ni,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          wr_ni,
  input  logic          order_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          cyc_wr_o
);
  localparam int UW = AW - BW;

  strobe_dec_t   dec;
  logic          load_ok;
  logic          step;
  logic [AW-1:0] base_q;
  burst_ord_e    ord_q;
  logic          valid_q;
  cyc_kind_e     kind_q;
  logic [BW-1:0] cnt;
  logic [BW-1:0] beat;

  strobe_decode u_dec (
    .ads_cpu_ni (ads_cpu_ni),
    .ads_ctl_ni (ads_ctl_ni),
    .ce1_ni     (ce1_ni),
    .ce2_i      (ce2_i),
    .ce3_ni     (ce3_ni),
    .dec_o      (dec)
  );

  assign load_ok = dec.start & dec.sel;
  assign step    = valid_q & ~dec.start & ~adv_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      ord_q   <= ORD_LINEAR;
      valid_q <= 1'b0;
      kind_q  <= CYC_RD;
    end else if (load_ok) begin
      base_q  <= addr_i;
      ord_q   <= burst_ord_e'(order_i);
      valid_q <= 1'b1;
      kind_q  <= (dec.proc || wr_ni) ? CYC_RD : CYC_WR;
    end else if (dec.start) begin
      valid_q <= 1'b0;
      kind_q  <= CYC_RD;
    end else if (valid_q) begin
      kind_q  <= wr_ni ? CYC_RD : CYC_WR;
    end else begin
      kind_q  <= CYC_RD;
    end
  end

  beat_counter #(.CW(BW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_ok),
    .step_i  (step),
    .cnt_o   (cnt)
  );

  beat_order #(.CW(BW)) u_ord (
    .start_i (base_q[BW-1:0]),
    .cnt_i   (cnt),
    .ord_i   (ord_q),
    .beat_o  (beat)
  );

  assign addr_o   = {base_q[AW-1:BW], beat};
  assign valid_o  = valid_q;
  assign cyc_wr_o = (kind_q == CYC_WR);

  // R4
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (ads_cpu_ni || ce1_ni) && ads_ctl_ni && adv_ni)
      |=> ($stable(addr_o) && valid_o));

  // R3
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (ads_cpu_ni || ce1_ni) && ads_ctl_ni)
      |=> addr_o[AW-1:BW] == $past(addr_o[AW-1:BW]));

  // R5
  proc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_cpu_ni && !ce1_ni && ce2_i && !ce3_ni) |=> (valid_o && !cyc_wr_o));

  // R8
  deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((!ads_cpu_ni && !ce1_ni) || !ads_ctl_ni) && (ce1_ni || !ce2_i || ce3_ni))
      |=> !valid_o);

  // R10
  priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_cpu_ni && !ads_ctl_ni && !ce1_ni && ce2_i && !ce3_ni)
      |=> (addr_o[AW-1:BW] == $past(addr_i[AW-1:BW]) && !cyc_wr_o));

  // R11
  idle_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !cyc_wr_o);
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ads_cpu_ni = 1'b1, ads_ctl_ni = 1'b1, adv_ni = 1'b1;
  logic          ce1_ni = 1'b0, ce2_i = 1'b1, ce3_ni = 1'b0;
  logic          wr_ni = 1'b1, order_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          valid_o, cyc_wr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .ads_cpu_ni(ads_cpu_ni), .ads_ctl_ni(ads_ctl_ni), .adv_ni(adv_ni),
    .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
    .wr_ni(wr_ni), .order_i(order_i),
    .addr_o(addr_o), .valid_o(valid_o), .cyc_wr_o(cyc_wr_o)
  );

  typedef struct packed {
    logic          cpu_n, ctl_n, adv_n, ce1_n, ce2, ce3_n, wr_n, ord;
    logic [AW-1:0] a;
    logic          ev, ew;
    logic [AW-1:0] ea;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    //cpu  ctl  adv  ce1  ce2  ce3  wr   ord  addr          v    w    exp addr
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h12345,1'b1,1'b0,18'h12345,8'd5},  // R5
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h12346,8'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h12347,8'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h12344,8'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,18'h00000,1'b1,1'b0,18'h12345,8'd3},  // R3 wrap
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,1'b1,1'b1,18'h12345,8'd6},  // R6
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,18'h3FFFF,1'b1,1'b0,18'h12345,8'd4},  // R4
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h00006,1'b1,1'b0,18'h00006,8'd2},  // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h00007,8'd2},  // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h00004,8'd2},  // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h00005,8'd2},  // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h00006,8'd9},  // R9
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,18'h3FFFF,1'b1,1'b0,18'h00006,8'd7},  // R7
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h2000B,1'b1,1'b1,18'h2000B,8'd12}, // R12
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,1'b1,1'b1,18'h2000A,8'd6},  // R6
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h15550,1'b1,1'b0,18'h15550,8'd10}, // R10
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,18'h00FFF,1'b0,1'b0,18'h15550,8'd8},  // R8 ce3
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,1'b0,1'b0,18'h15550,8'd8},  // R8 no step
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,18'h00FFF,1'b0,1'b0,18'h15550,8'd8},  // R8 ce1
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,18'h00FFF,1'b0,1'b0,18'h15550,8'd8},  // R8 ce2
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00003,1'b1,1'b0,18'h00003,8'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h00000,1'b1,1'b0,18'h00000,8'd1}   // R1 wrap
  };

  task automatic check(input string tag, input logic [AW+1:0] act, input logic [AW+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got valid/wr/addr %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2;
    check("R11 in reset", {valid_o, cyc_wr_o, addr_o}, '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R11 after reset", {valid_o, cyc_wr_o, addr_o}, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {ads_cpu_ni, ads_ctl_ni, adv_ni, ce1_ni, ce2_i, ce3_ni, wr_ni, order_i} =
        {VEC[i].cpu_n, VEC[i].ctl_n, VEC[i].adv_n, VEC[i].ce1_n,
         VEC[i].ce2, VEC[i].ce3_n, VEC[i].wr_n, VEC[i].ord};
      addr_i = VEC[i].a;
      @(posedge clk_i); #1;
      check($sformatf("R%0d vec %0d", VEC[i].req, i),
            {valid_o, cyc_wr_o, addr_o}, {VEC[i].ev, VEC[i].ew, VEC[i].ea});
    end

    // R11: reset in the middle of a write burst
    @(negedge clk_i);
    {ads_cpu_ni, ads_ctl_ni, adv_ni, ce1_ni, ce2_i, ce3_ni, wr_ni} = 7'b1010100;
    addr_i = 18'h0ABCD;
    @(posedge clk_i); #1;
    check("R12 pre-reset", {valid_o, cyc_wr_o, addr_o}, {1'b1, 1'b1, 18'h0ABCD});
    #3 rst_ni = 1'b0;
    #1 check("R11 async reset", {valid_o, cyc_wr_o, addr_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    {ads_cpu_ni, ads_ctl_ni, adv_ni, wr_ni} = 4'b1101;
    @(posedge clk_i); #1;
    check("R11 idle after reset", {valid_o, cyc_wr_o, addr_o}, '0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end
endmodule